// File: doc/BRIEF.md
# Serial-wire / JTAG debug port mode-switch detector

This block sits on the shared mode/data pin of a debug port that can speak either JTAG or the two-wire serial debug protocol. Every enabled rising edge of the debug clock it takes in one sampled line bit. It watches for long runs of high bits, which form a line reset. It also watches for the 16-bit selection words that move the port from one protocol to the other. The current protocol is reported on a single mode output that a downstream TAP controller or packet engine can use as its enable.

A selection word is only taken into account when it begins on the first low bit after a run of at least 50 consecutive high bits. Bits are compared least significant bit first. Only words that lead to the other mode are candidates. Any mismatching bit abandons the attempt, and nothing is matched again until another qualifying run of high bits has been seen. A line reset does not change the mode by itself. It only reports a one-cycle pulse.

Top module: `swj_mode_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters JTAG mode (`mode_swd` = 0) and drives both pulse outputs low.
- R2: `line_reset_pulse` goes high for exactly one clock cycle after the edge that samples the 50th consecutive enabled high bit. A run of 49 high bits produces no pulse. A longer run produces no second pulse until a low bit has been sampled.
- R3: In JTAG mode, the word 0xE79E sent LSB first and starting on the first low bit after a run of at least 50 high bits sets `mode_swd` to 1. The mode changes on the edge that samples the 16th bit, and `mode_change_pulse` is high for that one cycle only. Before that edge the mode is unchanged.
- R4: In JTAG mode, the older selection word 0xEDB6, framed and sent the same way, also sets `mode_swd` to 1 with a one-cycle `mode_change_pulse`.
- R5: In serial-wire mode, the word 0xE73C, framed and sent the same way, sets `mode_swd` to 0 with a one-cycle `mode_change_pulse`.
- R6: A selection word preceded by a run of only 49 high bits is ignored. The mode and `mode_change_pulse` are unaffected.
- R7: A word with any wrong bit aborts matching. A correct word that follows it without a new run of at least 50 high bits is ignored.
- R8: A word that selects the mode already in force is ignored: 0xE73C in JTAG mode, and 0xE79E in serial-wire mode.
- R9: A cycle with `en` low is not sampled. The run count, the matching progress and the mode are all held, whatever level `line_bit` has.
- R10: High bits at the tail of a selection word count toward the next run. After 0xE79E, whose top three bits are 1, `line_reset_pulse` fires on the 47th high bit sent after the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock; line sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Clock enable; a cycle with `en` low is not sampled |
| line_bit | input | 1 | Sampled level of the shared mode/data line |
| mode_swd | output | 1 | 1 = serial-wire mode, 0 = JTAG mode |
| line_reset_pulse | output | 1 | One-cycle pulse on the 50th consecutive high bit |
| mode_change_pulse | output | 1 | One-cycle pulse when the mode flips |

## Verification
The edge that samples the last bit of a selection word does two jobs at once. It completes the match and flips the mode. Because that bit is high, it is also the third high bit of the run that serves as the trailing line reset. The bench sends a full word and checks that the mode flips exactly on the 16th bit and that the change pulse drops on the next bit. It then counts further high bits one by one and requires the line-reset pulse on the 47th and on no earlier one. If the tail bits were lost or counted twice, the pulse would arrive in a different cycle. Words that are interrupted by disabled cycles carrying the opposite level show that a disabled cycle neither advances the run count nor advances the match.

// File: rtl/swj_pkg.sv
// Shared definitions for the debug port mode-switch detector.
// Assumes every selection word has the same width and that all of them start with a 0 bit.
package swj_pkg;

    typedef enum logic {
        MODE_JTAG = 1'b0,
        MODE_SWD  = 1'b1
    } mode_e;

    localparam int SEL_W    = 16;
    localparam int SEL_NUM  = 3;
    localparam int RUN_LEN  = 50;

    // Candidate words (LSB sent first) and the mode each one selects.
    localparam logic [SEL_W-1:0] SEL_WORDS [SEL_NUM] = '{16'hE79E, 16'hEDB6, 16'hE73C};
    localparam mode_e            SEL_MODE  [SEL_NUM] = '{MODE_SWD, MODE_SWD, MODE_JTAG};

endpackage

// File: rtl/swj_run_counter.sv
// Counts consecutive enabled high bits on the line, saturating at RUN_MIN.
// It raises a one-cycle pulse when the count reaches RUN_MIN and reports when a qualifying run is in place.
// Assumes a synchronous active-low reset.
module swj_run_counter #(
    parameter int RUN_MIN = swj_pkg::RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_in,
    output logic run_met,
    output logic lr_pulse
);
    localparam int CW = $clog2(RUN_MIN + 1);

    logic [CW-1:0] ones_cnt;

    // The run count is held at RUN_MIN once it gets there.
    assign run_met = (ones_cnt == CW'(RUN_MIN));

    // Count high bits, clear the count on a low bit, and pulse on the last high bit of a qualifying run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_cnt <= '0;
            lr_pulse <= 1'b0;
        end else begin
            lr_pulse <= 1'b0;
            if (en) begin
                if (bit_in) begin
                    if (ones_cnt < CW'(RUN_MIN))
                        ones_cnt <= ones_cnt + 1'b1;
                    if (ones_cnt == CW'(RUN_MIN - 1))
                        lr_pulse <= 1'b1;
                end else begin
                    ones_cnt <= '0;
                end
            end
        end
    end

    // R2
    lr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lr_pulse |=> !lr_pulse);

    // R2
    lr_at_full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lr_pulse |-> run_met);

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(ones_cnt));

endmodule

// File: rtl/swj_word_matcher.sv
// Matches the incoming bit stream against the selection words, LSB first.
// A word may start only on a low bit taken while a qualifying run is in place.
// Only words that lead to a mode other than cur_mode are candidates.
// On the 16th matching bit, hit is raised combinationally and hit_mode gives the new mode.
module swj_word_matcher
    import swj_pkg::*;
#(
    parameter int W = SEL_W,
    parameter int N = SEL_NUM
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  bit_in,
    input  logic  run_met,
    input  mode_e cur_mode,
    output logic  hit,
    output mode_e hit_mode
);
    localparam int IW = $clog2(W);

    logic          active;
    logic [IW-1:0] idx;
    logic [N-1:0]  alive;
    logic [N-1:0]  bit_ok;
    logic [N-1:0]  alive_nxt;
    logic [IW-1:0] bit_pos;
    logic          step;
    logic          last_bit;

    assign bit_pos  = active ? idx : '0;
    assign step     = en && (active || (run_met && !bit_in));
    assign last_bit = active && (idx == IW'(W - 1));

    // Each candidate survives while its bit agrees with the line and it leads to the other mode.
    for (genvar c = 0; c < N; c++) begin : g_cand
        assign bit_ok[c]    = (bit_in == SEL_WORDS[c][bit_pos]) && (SEL_MODE[c] != cur_mode);
        assign alive_nxt[c] = (active ? alive[c] : 1'b1) && bit_ok[c];
    end

    assign hit = step && last_bit && (|alive_nxt);

    // Pick the mode of a surviving candidate; all survivors share the same target.
    always_comb begin
        hit_mode = cur_mode;
        for (int c = 0; c < N; c++)
            if (alive_nxt[c])
                hit_mode = SEL_MODE[c];
    end

    // Advance through the word, or drop out on a mismatch or on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            alive  <= '0;
        end else if (step) begin
            alive <= alive_nxt;
            if (last_bit || !(|alive_nxt)) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                active <= 1'b1;
                idx    <= bit_pos + 1'b1;
            end
        end
    end

    // R6
    start_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(run_met));

    // R7
    idle_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (idx == '0));

    // R9
    match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(idx) && $stable(active)));

endmodule

// File: rtl/swj_mode_detect.sv
// Top level of the debug port mode-switch detector.
// It holds the current protocol mode and flips it when the word matcher reports a complete selection word.
// It also passes out the line-reset pulse from the run counter. Comes up in JTAG mode after reset.
module swj_mode_detect
    import swj_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic line_bit,
    output logic mode_swd,
    output logic line_reset_pulse,
    output logic mode_change_pulse
);
    mode_e mode_q;
    mode_e hit_mode;
    logic  run_met;
    logic  hit;

    swj_run_counter #(.RUN_MIN(RUN_LEN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .bit_in   (line_bit),
        .run_met  (run_met),
        .lr_pulse (line_reset_pulse)
    );

    swj_word_matcher #(.W(SEL_W), .N(SEL_NUM)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .bit_in   (line_bit),
        .run_met  (run_met),
        .cur_mode (mode_q),
        .hit      (hit),
        .hit_mode (hit_mode)
    );

    // Register the mode and raise the one-cycle change pulse on a completed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q            <= MODE_JTAG;
            mode_change_pulse <= 1'b0;
        end else begin
            mode_change_pulse <= 1'b0;
            if (hit) begin
                mode_q            <= hit_mode;
                mode_change_pulse <= 1'b1;
            end
        end
    end

    assign mode_swd = (mode_q == MODE_SWD);

    // R3
    change_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_change_pulse |-> (mode_swd != $past(mode_swd)));

    // R3
    flip_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_swd != $past(mode_swd)) |-> mode_change_pulse);

    // R3
    change_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_change_pulse |=> !mode_change_pulse);

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(mode_swd));

endmodule

// File: tb/swj_mode_detect_test.sv
`timescale 1ns/1ps
// Directed bench for swj_mode_detect: one task per scenario, each task checks its own results.
module swj_mode_detect_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic line_bit = 1'b0;
    logic mode_swd, line_reset_pulse, mode_change_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    swj_mode_detect uut (
        .clk(clk), .rst_n(rst_n), .en(en), .line_bit(line_bit),
        .mode_swd(mode_swd), .line_reset_pulse(line_reset_pulse),
        .mode_change_pulse(mode_change_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en = 1'b0; line_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One enabled bit; returns at the next falling edge with outputs settled.
    task automatic send_bit(input logic b);
        line_bit = b; en = 1'b1;
        @(negedge clk);
        en = 1'b0;
    endtask

    task automatic idle(input int n, input logic b);
        en = 1'b0; line_bit = b;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_ones(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            send_bit(1'b1);
            if (line_reset_pulse) pulses++;
        end
    endtask

    // Sends a word LSB first; gap_at >= 0 inserts disabled cycles carrying the wrong level.
    task automatic send_word(input logic [15:0] w, input int gap_at, output int changes);
        changes = 0;
        for (int i = 0; i < 16; i++) begin
            if (i == gap_at) idle(3, ~w[i]);
            send_bit(w[i]);
            if (mode_change_pulse) changes++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(mode_swd == 1'b0, "R1 mode", mode_swd, 0);
        chk(!line_reset_pulse && !mode_change_pulse, "R1 pulses",
            {line_reset_pulse, mode_change_pulse}, 0);
    endtask

    task automatic t_line_reset();
        int p;
        do_reset();
        send_ones(49, p);
        chk(p == 0, "R2 49 ones", p, 0);
        send_bit(1'b1);
        chk(line_reset_pulse == 1'b1, "R2 50th bit", line_reset_pulse, 1);
        send_bit(1'b1);
        chk(line_reset_pulse == 1'b0, "R2 one cycle", line_reset_pulse, 0);
        send_ones(70, p);
        chk(p == 0, "R2 no repeat", p, 0);
        send_bit(1'b0);
        send_ones(50, p);
        chk(p == 1, "R2 after low bit", p, 1);
        chk(mode_swd == 1'b0, "R2 no mode change", mode_swd, 0);
    endtask

    task automatic t_short_run();
        int p, c;
        do_reset();
        send_ones(49, p);
        send_word(16'hE79E, -1, c);
        chk(c == 0 && mode_swd == 1'b0, "R6 short run", {c[7:0], 7'd0, mode_swd}, 0);
    endtask

    task automatic t_to_swd_and_back();
        int p, c;
        logic [15:0] w;
        do_reset();
        w = 16'hE79E;
        send_ones(60, p);
        for (int i = 0; i < 16; i++) begin
            send_bit(w[i]);
            if (i < 15) begin
                if (mode_swd || mode_change_pulse)
                    chk(1'b0, "R3 early change", {mode_swd, mode_change_pulse}, 0);
            end
        end
        chk(mode_swd == 1'b1, "R3 mode after word", mode_swd, 1);
        chk(mode_change_pulse == 1'b1, "R3 pulse", mode_change_pulse, 1);
        p = 0;
        for (int k = 1; k <= 47; k++) begin
            send_bit(1'b1);
            if (k == 1)
                chk(mode_change_pulse == 1'b0, "R3 pulse one cycle", mode_change_pulse, 0);
            if (k < 47 && line_reset_pulse) p++;
            if (k == 47)
                chk(line_reset_pulse == 1'b1, "R10 pulse on 47th", line_reset_pulse, 1);
        end
        chk(p == 0, "R10 no early pulse", p, 0);
        send_bit(1'b0);
        send_ones(50, p);
        send_word(16'hE79E, -1, c);
        chk(c == 0 && mode_swd == 1'b1, "R8 same-mode word in SWD", c, 0);
        send_ones(55, p);
        send_word(16'hE73C, -1, c);
        chk(c == 1 && mode_swd == 1'b0, "R5 back to JTAG", {c[7:0], 7'd0, mode_swd}, 16'h0100);
    endtask

    task automatic t_old_word();
        int p, c;
        do_reset();
        send_ones(55, p);
        send_word(16'hEDB6, -1, c);
        chk(c == 1 && mode_swd == 1'b1, "R4 older word", {c[7:0], 7'd0, mode_swd}, 16'h0101);
    endtask

    task automatic t_wrong_mode();
        int p, c;
        do_reset();
        send_ones(50, p);
        send_word(16'hE73C, -1, c);
        chk(c == 0 && mode_swd == 1'b0, "R8 JTAG word in JTAG", c, 0);
    endtask

    task automatic t_abort();
        int p, c;
        do_reset();
        send_ones(50, p);
        send_word(16'hE79E ^ 16'h0020, -1, c);
        chk(c == 0 && mode_swd == 1'b0, "R7 bad word", c, 0);
        send_word(16'hE79E, -1, c);
        chk(c == 0 && mode_swd == 1'b0, "R7 no rearm", c, 0);
        send_bit(1'b1);
        send_ones(50, p);
        send_word(16'hE79E, -1, c);
        chk(c == 1 && mode_swd == 1'b1, "R7 rearmed by run", c, 1);
    endtask

    task automatic t_enable();
        int p, c;
        do_reset();
        send_ones(49, p);
        idle(4, 1'b0);
        chk(line_reset_pulse == 1'b0, "R9 idle no pulse", line_reset_pulse, 0);
        send_bit(1'b1);
        chk(line_reset_pulse == 1'b1, "R9 run kept over idle", line_reset_pulse, 1);
        send_word(16'hE79E, 7, c);
        chk(c == 1 && mode_swd == 1'b1, "R9 word with gap", c, 1);
        idle(5, 1'b0);
        chk(mode_swd == 1'b1, "R9 mode held", mode_swd, 1);
    endtask

    initial begin
        t_reset();
        t_line_reset();
        t_short_run();
        t_to_swd_and_back();
        t_old_word();
        t_wrong_mode();
        t_abort();
        t_enable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule